// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Front End

This block is the synchronous control front end of a 36-bit pipelined burst SRAM. It has a small internal array of 256 words, organised as four 9-bit byte lanes. On every rising clock edge it samples three chip enables, two address strobes, an advance input, the write enables and a sleep input. From these it classifies the cycle as one of the following:

- a deselect;
- a burst start that reads or writes at the external address;
- a continue at the next burst address;
- a suspend that reuses the current burst address;
- an idle cycle.

The processor strobe (`cpu_stb_n`) always starts a read, whatever the write enables show. The controller strobe (`ctl_stb_n`) can start a write in its own cycle. A write that follows a processor-strobe start happens on later continue or suspend cycles. Read data comes out through one pipeline register. The output enable gates the drive indication without reference to the clock.

Top module: `pbsram_ctrl`

## Requirements
- R1: A cycle is a write when `gwe_n` is low (all four lanes), or when `lane_gate_n` is low and at least one bit of `lane_en_n` is low. Otherwise it is a read.
- R2: With `cpu_stb_n` low, `sleep_i` low and the chip selected (`cs_a_n`=0, `cs_b`=1, `cs_c_n`=0), the cycle starts a read burst at `addr_i` and writes nothing, whatever the write enables show.
- R3: With `cpu_stb_n` high, `ctl_stb_n` low and the chip selected, the cycle starts a burst at `addr_i`. If R1 says write, `wdata_i` is written to that address on the same edge.
- R4: A continue cycle has both strobes high, `step_n` low and a burst active. It advances the beat count by one and uses the next burst address. In linear order (`il_mode`=0 at the burst start), the two low address bits are (start low bits + count) mod 4, so the burst wraps inside its aligned group of four words.
- R5: In interleaved order (`il_mode`=1 at the burst start), the two low address bits are start low bits XOR count. The order is latched at the burst start, so changing `il_mode` during the burst has no effect.
- R6: A suspend cycle has both strobes high, `step_n` high and a burst active. It reuses the current burst address and may read or write there.
- R7: A strobe sampled low while any chip enable is inactive is a deselect. It ends the burst, later continue and suspend cycles do nothing until a new start, and the output stage that follows floats.
- R8: A read sampled at edge k shows its word on `rdata_o` after edge k+1. That word includes every write sampled at edge k or earlier.
- R9: `rdrive_o` is high only when `oe_n` is low, `sleep_i` is low and the output stage holds a read. It follows `oe_n` without a clock edge. Output stages of write cycles float.
- R10: While `sleep_i` is high, strobes and enables are ignored: no write, no change to the burst state, and the outputs float. A burst interrupted by sleep resumes where it stopped.
- R11: A byte write with `gwe_n` high updates only the lanes whose `lane_en_n` bit is low. Lane i is `wdata_i[9i+8:9i]`. Any lane combination is allowed.
- R12: After reset the outputs float and no burst is active, so continue and suspend cycles neither write nor drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_i | input | 1 | Power-down snooze request, active high |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low, always starts a read |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| gwe_n | input | 1 | Global write, active low, all lanes |
| lane_gate_n | input | 1 | Byte-write gate, active low |
| lane_en_n | input | 4 | Per-lane write enables, active low |
| il_mode | input | 1 | Burst order at start: 0 linear, 1 interleaved |
| addr_i | input | 8 | External word address |
| wdata_i | input | 36 | Write data |
| oe_n | input | 1 | Output enable, active low, not clocked |
| rdata_o | output | 36 | Pipelined read data |
| rdrive_o | output | 1 | High when the data pins would drive |

## Verification
A read sampled at edge k is due on `rdata_o` and `rdrive_o` after edge k+1. The bench reference model has the same two stages: a registered address and then an output stage loaded from the shadow memory before that edge's write is applied. Outputs are compared at the falling edge that follows each rising edge, before any input changes. Burst state, beat count and writes are due on the edge that samples the cycle, and they become visible through later reads. The effect of `oe_n` is due at once, so it is checked 1 ns after `oe_n` toggles, with no clock edge in between.

// File: rtl/pbsram_pkg.sv
// Shared types and helpers for the pipelined burst SRAM front end.
// Assumes a four-beat burst stepped in the two low address bits.
package pbsram_pkg;

    localparam int BURST_BITS = 2;

    typedef enum logic [2:0] {
        CY_NOP,
        CY_DESEL,
        CY_START_RD,
        CY_START_CS,
        CY_CONT,
        CY_SUSP,
        CY_SLEEP
    } cyc_e;

    // Low address bits of beat `cnt` for a burst that started at `start`.
    function automatic logic [BURST_BITS-1:0] burst_idx(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] cnt,
        input logic                  il
    );
        return il ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/pbsram_decode.sv
// Cycle classifier: turns sampled strobes, enables and sleep into one cycle
// kind, and derives the write decision and per-lane write mask.
// Assumes sel_i is already the AND of all chip enables.
module pbsram_decode
    import pbsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sleep_i,
    input  logic             sel_i,
    input  logic             cpu_stb_n,
    input  logic             ctl_stb_n,
    input  logic             step_n,
    input  logic             gwe_n,
    input  logic             lane_gate_n,
    input  logic [LANES-1:0] lane_en_n,
    input  logic             burst_act,
    output cyc_e             kind,
    output logic             wr_act,
    output logic [LANES-1:0] lane_we
);

    // Write mask: the global write takes every lane, the byte gate takes the enabled lanes.
    always_comb begin
        if (!gwe_n)
            lane_we = '1;
        else if (!lane_gate_n)
            lane_we = ~lane_en_n;
        else
            lane_we = '0;
        wr_act = |lane_we;
    end

    // Cycle kind: sleep first, then the processor strobe, then the controller strobe, then burst control.
    always_comb begin
        if (sleep_i)
            kind = CY_SLEEP;
        else if (!cpu_stb_n)
            kind = sel_i ? CY_START_RD : CY_DESEL;
        else if (!ctl_stb_n)
            kind = sel_i ? CY_START_CS : CY_DESEL;
        else if (!burst_act)
            kind = CY_NOP;
        else if (step_n)
            kind = CY_SUSP;
        else
            kind = CY_CONT;
    end

endmodule

// File: rtl/pbsram_burst.sv
// Burst address unit: holds the start address, the beat count and the order,
// and presents the effective address of the current cycle.
// Assumes the cycle kind is stable for the whole clock period.
module pbsram_burst
    import pbsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cyc_e          kind,
    input  logic [AW-1:0] ext_addr,
    input  logic          il_i,
    output logic [AW-1:0] cur_addr,
    output logic          act
);

    localparam int BB = BURST_BITS;

    logic [AW-1:0] base_q;
    logic [BB-1:0] cnt_q;
    logic [BB-1:0] cnt_nx;
    logic          il_q;
    logic          act_q;

    assign act = act_q;

    // Effective address: the external address on a start, the next beat on a continue, otherwise the current beat.
    always_comb begin
        cnt_nx = cnt_q + 1'b1;
        case (kind)
            CY_START_RD, CY_START_CS: cur_addr = ext_addr;
            CY_CONT:  cur_addr = {base_q[AW-1:BB], burst_idx(base_q[BB-1:0], cnt_nx, il_q)};
            default:  cur_addr = {base_q[AW-1:BB], burst_idx(base_q[BB-1:0], cnt_q, il_q)};
        endcase
    end

    // Burst state: load on a start, step on a continue, clear on a deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            il_q   <= 1'b0;
            act_q  <= 1'b0;
        end else begin
            case (kind)
                CY_START_RD, CY_START_CS: begin
                    base_q <= ext_addr;
                    cnt_q  <= '0;
                    il_q   <= il_i;
                    act_q  <= 1'b1;
                end
                CY_CONT:  cnt_q <= cnt_nx;
                CY_DESEL: act_q <= 1'b0;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/pbsram_array.sv
// Lane-split storage array with one registered address stage and one
// registered output stage. A write lands on the edge that samples it.
// Assumes addr is the effective address of the current cycle.
module pbsram_array #(
    parameter int AW    = 8,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [LANES-1:0]    lane_we,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] wdata,
    input  logic                rd_req,
    output logic [LANES*LW-1:0] dout,
    output logic                drv
);

    localparam int DEPTH = 1 << AW;

    logic          rd1_q;
    logic [AW-1:0] a1_q;
    logic          drv_q;

    assign drv = drv_q;

    // Pipeline control: register the read request and address, then the drive flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd1_q <= 1'b0;
            a1_q  <= '0;
            drv_q <= 1'b0;
        end else begin
            rd1_q <= rd_req;
            a1_q  <= addr;
            drv_q <= rd1_q;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];
        logic [LW-1:0] lane_q;

        // Lane write: store this lane's slice when the lane is enabled.
        always_ff @(posedge clk) begin
            if (we && lane_we[g])
                mem[addr] <= wdata[g*LW +: LW];
        end

        // Lane output register: read from the address registered one cycle earlier.
        always_ff @(posedge clk) begin
            lane_q <= mem[a1_q];
        end

        assign dout[g*LW +: LW] = lane_q;
    end

endmodule

// File: rtl/pbsram_ctrl.sv
// Top of the pipelined burst SRAM front end. Combines the chip enables,
// classifies the cycle, steers the burst address into the array and gates
// the output drive with the unclocked output enable and with sleep.
// Assumes all inputs except oe_n are synchronous to clk.
module pbsram_ctrl
    import pbsram_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_i,
    input  logic                cs_a_n,
    input  logic                cs_b,
    input  logic                cs_c_n,
    input  logic                cpu_stb_n,
    input  logic                ctl_stb_n,
    input  logic                step_n,
    input  logic                gwe_n,
    input  logic                lane_gate_n,
    input  logic [LANES-1:0]    lane_en_n,
    input  logic                il_mode,
    input  logic [AW-1:0]       addr_i,
    input  logic [LANES*LW-1:0] wdata_i,
    input  logic                oe_n,
    output logic [LANES*LW-1:0] rdata_o,
    output logic                rdrive_o
);

    cyc_e             kind;
    logic             sel;
    logic             wr_act;
    logic [LANES-1:0] lane_we;
    logic             burst_act;
    logic [AW-1:0]    burst_addr;
    logic             arr_we;
    logic             arr_rd;
    logic             stage_drv;
    logic             data_cyc;

    assign sel = !cs_a_n && cs_b && !cs_c_n;

    pbsram_decode #(.LANES(LANES)) u_dec (
        .sleep_i     (sleep_i),
        .sel_i       (sel),
        .cpu_stb_n   (cpu_stb_n),
        .ctl_stb_n   (ctl_stb_n),
        .step_n      (step_n),
        .gwe_n       (gwe_n),
        .lane_gate_n (lane_gate_n),
        .lane_en_n   (lane_en_n),
        .burst_act   (burst_act),
        .kind        (kind),
        .wr_act      (wr_act),
        .lane_we     (lane_we)
    );

    pbsram_burst #(.AW(AW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .ext_addr (addr_i),
        .il_i     (il_mode),
        .cur_addr (burst_addr),
        .act      (burst_act)
    );

    // Access steering: the processor-strobe start is always a read; other data cycles follow the write decode.
    always_comb begin
        data_cyc = (kind == CY_START_CS) || (kind == CY_CONT) || (kind == CY_SUSP);
        arr_we   = data_cyc && wr_act;
        arr_rd   = (kind == CY_START_RD) || (data_cyc && !wr_act);
    end

    pbsram_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (arr_we),
        .lane_we (lane_we),
        .addr    (burst_addr),
        .wdata   (wdata_i),
        .rd_req  (arr_rd),
        .dout    (rdata_o),
        .drv     (stage_drv)
    );

    assign rdrive_o = stage_drv && !oe_n && !sleep_i;

endmodule

// File: rtl/pbsram_chk.sv
// Assertion checker for pbsram_ctrl, attached by bind below.
module pbsram_chk #(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_i,
    input logic             cs_a_n,
    input logic             cs_b,
    input logic             cs_c_n,
    input logic             cpu_stb_n,
    input logic             ctl_stb_n,
    input logic             step_n,
    input logic             gwe_n,
    input logic             lane_gate_n,
    input logic [LANES-1:0] lane_en_n,
    input logic             rdrive_o,
    input logic             arr_we,
    input logic             burst_act,
    input logic [AW-1:0]    burst_addr
);

    logic c_sel, c_wr, c_cont, c_susp, c_desel;

    always_comb begin
        c_sel   = !cs_a_n && cs_b && !cs_c_n;
        c_wr    = !gwe_n || (!lane_gate_n && !(&lane_en_n));
        c_cont  = !sleep_i && cpu_stb_n && ctl_stb_n && !step_n && burst_act;
        c_susp  = !sleep_i && cpu_stb_n && ctl_stb_n && step_n && burst_act;
        c_desel = !sleep_i && (!cpu_stb_n || !ctl_stb_n) && !c_sel;
    end

    // R2
    cpu_start_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && c_sel && !sleep_i) |-> !arr_we);

    // R3
    ctl_start_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stb_n && !ctl_stb_n && c_sel && !sleep_i && c_wr) |-> arr_we);

    // R4
    cont_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_cont |-> (burst_addr[AW-1:2] == $past(burst_addr[AW-1:2])) &&
                   (burst_addr[1:0] != $past(burst_addr[1:0])));

    // R6
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_susp |-> burst_addr == $past(burst_addr));

    // R7
    desel_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_desel |=> !burst_act);

    // R7
    desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_desel |=> ##1 !rdrive_o);

    // R10
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> (!arr_we && !rdrive_o));

    // R10
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (burst_act == $past(burst_act)));

endmodule

bind pbsram_ctrl pbsram_chk #(.AW(AW), .LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .cs_a_n      (cs_a_n),
    .cs_b        (cs_b),
    .cs_c_n      (cs_c_n),
    .cpu_stb_n   (cpu_stb_n),
    .ctl_stb_n   (ctl_stb_n),
    .step_n      (step_n),
    .gwe_n       (gwe_n),
    .lane_gate_n (lane_gate_n),
    .lane_en_n   (lane_en_n),
    .rdrive_o    (rdrive_o),
    .arr_we      (arr_we),
    .burst_act   (burst_act),
    .burst_addr  (burst_addr)
);

// File: tb/sim_pbsram_ctrl.sv
`timescale 1ns/1ps
module sim_pbsram_ctrl;

    localparam int AW = 8;
    localparam int LANES = 4;
    localparam int LW = 9;
    localparam int DW = LANES*LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_i, cs_a_n, cs_b, cs_c_n, cpu_stb_n, ctl_stb_n, step_n;
    logic gwe_n, lane_gate_n, il_mode, oe_n;
    logic [LANES-1:0] lane_en_n;
    logic [AW-1:0] addr_i;
    logic [DW-1:0] wdata_i;
    logic [DW-1:0] rdata_o;
    logic rdrive_o;

    always #4 clk = ~clk;

    pbsram_ctrl #(.AW(AW), .LANES(LANES), .LW(LW)) u0 (.*);

    int n_chk = 0;
    int n_fail = 0;
    string tag = "R12";

    // Reference model state
    logic [DW-1:0] shadow [DEPTH];
    logic m_act, m_il, m_rd1, m_drv;
    logic [AW-1:0] m_base, m_a1;
    logic [1:0] m_cnt;
    logic [DW-1:0] m_dat;

    function automatic logic [1:0] beat(input logic [1:0] s, input logic [1:0] c, input logic il);
        return il ? (s ^ c) : (s + c);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s t=%0t actual %h expected %h", req, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        m_act = 0; m_rd1 = 0; m_drv = 0; m_il = 0;
        m_base = '0; m_a1 = '0; m_cnt = '0; m_dat = '0;
    endtask

    // Advance the model by one edge, using the inputs held across it.
    task automatic model_edge();
        logic sel, wr, start, cont, data;
        logic [DW-1:0] mask;
        logic [AW-1:0] eff;
        m_drv = m_rd1;
        m_dat = shadow[m_a1];
        if (sleep_i) begin
            m_rd1 = 0;
            return;
        end
        sel = !cs_a_n && cs_b && !cs_c_n;
        mask = '0;
        for (int l = 0; l < LANES; l++)
            if (!gwe_n || (!lane_gate_n && !lane_en_n[l])) mask[l*LW +: LW] = '1;
        wr = |mask;
        start = 0; cont = 0; data = 0;
        if (!cpu_stb_n || !ctl_stb_n) begin
            if (!sel) begin
                m_act = 0; m_rd1 = 0;
                return;
            end
            start = 1;
            data = cpu_stb_n;
        end else if (m_act) begin
            cont = !step_n;
            data = 1;
        end else begin
            m_rd1 = 0;
            return;
        end
        if (start) begin
            m_base = addr_i; m_cnt = 0; m_il = il_mode; m_act = 1;
            eff = addr_i;
        end else begin
            if (cont) m_cnt = m_cnt + 1'b1;
            eff = {m_base[AW-1:2], beat(m_base[1:0], m_cnt, m_il)};
        end
        m_a1 = eff;
        if (data && wr) begin
            m_rd1 = 0;
            shadow[eff] = (shadow[eff] & ~mask) | (wdata_i & mask);
        end else begin
            m_rd1 = 1;
        end
    endtask

    task automatic check_out();
        logic exp_oe;
        exp_oe = m_drv && !oe_n && !sleep_i;
        chk(rdrive_o == exp_oe, tag, DW'(rdrive_o), DW'(exp_oe));
        if (exp_oe) chk(rdata_o == m_dat, tag, rdata_o, m_dat);
    endtask

    task automatic cyc();
        @(posedge clk);
        if (rst_n) model_edge(); else model_reset();
        @(negedge clk);
        check_out();
    endtask

    task automatic idle_in();
        sleep_i = 0; cs_a_n = 0; cs_b = 1; cs_c_n = 0;
        cpu_stb_n = 1; ctl_stb_n = 1; step_n = 1;
        gwe_n = 1; lane_gate_n = 1; lane_en_n = '1; oe_n = 0;
        wdata_i = {$urandom, $urandom};
    endtask

    task automatic ctl_write(input logic [AW-1:0] a);
        idle_in(); ctl_stb_n = 0; gwe_n = 0; addr_i = a; cyc();
    endtask

    task automatic ctl_read(input logic [AW-1:0] a, input logic il);
        idle_in(); ctl_stb_n = 0; addr_i = a; il_mode = il; cyc();
    endtask

    task automatic go(input int n);
        for (int i = 0; i < n; i++) begin idle_in(); step_n = 0; cyc(); end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle_in(); addr_i = '0; il_mode = 0;
        model_reset();
        // R12: outputs float while in reset
        repeat (3) cyc();
        rst_n = 1;
        // R12: continue and suspend with no burst neither write nor drive
        tag = "R12";
        idle_in(); step_n = 0; gwe_n = 0; cyc();
        idle_in(); cyc(); cyc();

        // R3: preload every word with single writes on the controller strobe
        tag = "R3";
        for (int a = 0; a < DEPTH; a++) ctl_write(AW'(a));

        // R8: a write followed at once by a read of the same word
        tag = "R8";
        ctl_write(8'h40); ctl_read(8'h40, 0); idle_in(); cyc(); cyc();

        // R2: processor strobe with writes requested still reads
        tag = "R2";
        idle_in(); cpu_stb_n = 0; gwe_n = 0; addr_i = 8'h05; cyc();
        idle_in(); cyc(); cyc();
        ctl_read(8'h05, 0); idle_in(); cyc(); cyc();
        // R2: write after a processor-strobe start happens on a later suspend cycle
        idle_in(); cpu_stb_n = 0; addr_i = 8'h09; cyc();
        idle_in(); gwe_n = 0; cyc();
        ctl_read(8'h09, 0); idle_in(); cyc(); cyc();

        // R1: gate low with no lane enabled is a read; global write covers all lanes
        tag = "R1";
        idle_in(); ctl_stb_n = 0; lane_gate_n = 0; addr_i = 8'h11; cyc();
        idle_in(); ctl_stb_n = 0; gwe_n = 0; lane_gate_n = 1; lane_en_n = 4'b1111; addr_i = 8'h12; cyc();
        ctl_read(8'h11, 0); ctl_read(8'h12, 0); idle_in(); cyc(); cyc();

        // R11: byte-masked writes, several lane combinations
        tag = "R11";
        for (int m = 0; m < 16; m++) begin
            idle_in(); ctl_stb_n = 0; lane_gate_n = 0; lane_en_n = 4'(m); addr_i = 8'h20; cyc();
            ctl_read(8'h20, 0);
        end
        idle_in(); cyc(); cyc();

        // R4: linear burst from low bits 2, through the wrap
        tag = "R4";
        ctl_read(8'h12, 0); go(7); idle_in(); cyc(); cyc();

        // R5: interleaved burst from low bits 1, order input changed mid-burst
        tag = "R5";
        ctl_read(8'h31, 1);
        idle_in(); step_n = 0; il_mode = 0; cyc();
        go(4); idle_in(); cyc(); cyc();

        // R6: suspend holds the address, including a write while suspended
        tag = "R6";
        ctl_read(8'h52, 0); idle_in(); cyc(); cyc();
        idle_in(); gwe_n = 0; cyc();
        idle_in(); cyc();
        go(1); idle_in(); cyc(); cyc();

        // R7: each chip enable deselects in turn; later continues do nothing
        tag = "R7";
        for (int e = 0; e < 3; e++) begin
            ctl_read(8'h60, 0);
            idle_in(); ctl_stb_n = 0; addr_i = 8'h70;
            if (e == 0) cs_a_n = 1; else if (e == 1) cs_b = 0; else cs_c_n = 1;
            cyc();
            idle_in(); step_n = 0; gwe_n = 0; cyc();
            idle_in(); cyc(); cyc();
        end

        // R9: output enable acts without a clock; write stages float
        tag = "R9";
        ctl_read(8'h44, 0); idle_in(); cyc();
        oe_n = 1; #1;
        chk(rdrive_o == 1'b0, "R9", DW'(rdrive_o), '0);
        oe_n = 0; #1;
        chk(rdrive_o == 1'b1, "R9", DW'(rdrive_o), DW'(1));
        @(negedge clk);
        ctl_write(8'h44); idle_in(); cyc(); cyc();

        // R10: sleep in the middle of a burst, with noisy inputs
        tag = "R10";
        ctl_read(8'h80, 0); go(1);
        for (int s = 0; s < 3; s++) begin
            idle_in(); sleep_i = 1; ctl_stb_n = 0; gwe_n = 0; step_n = 0; addr_i = 8'h90; cyc();
        end
        go(2); idle_in(); cyc(); cyc();
        ctl_read(8'h90, 0); idle_in(); cyc(); cyc();

        // R8: constrained random traffic
        tag = "R8";
        for (int i = 0; i < 4000; i++) begin
            sleep_i     = ($urandom % 16) == 0;
            cs_a_n      = ($urandom % 12) == 0;
            cs_b        = ($urandom % 12) != 0;
            cs_c_n      = ($urandom % 12) == 0;
            cpu_stb_n   = ($urandom % 6) != 0;
            ctl_stb_n   = ($urandom % 5) != 0;
            step_n      = 1'($urandom);
            gwe_n       = ($urandom % 4) != 0;
            lane_gate_n = ($urandom % 3) != 0;
            lane_en_n   = 4'($urandom);
            il_mode     = 1'($urandom);
            oe_n        = ($urandom % 8) == 0;
            addr_i      = AW'($urandom);
            wdata_i     = {$urandom, $urandom};
            cyc();
        end

        finish_run();
    end

endmodule